// File: doc/BRIEF.md
# Loop-Exit Local Branch Predictor

This block predicts the direction of conditional branches from each branch's own past behaviour, and it is aimed at loop-closing branches. A small table, addressed by a few bits of the branch address, keeps one history entry per branch. An entry runs in one of two states. In shift state it is a shift register of recent outcomes. In count state it is a run-length counter of identical outcomes. The entry selects one 2-bit saturating counter in a shared pattern table, and that counter's upper bit is the prediction.

Because the entry turns into a counter once its history fills with a single direction, a loop whose trip count is far larger than the history width can still have its exit predicted. The counter value reached on the last iteration picks its own pattern counter, and that counter learns not-taken. The fetch side presents a lookup index and reads the prediction in the same cycle. The resolve side presents an update index and the resolved outcome, and both tables change on the next clock edge.

Each entry has two states, HIST_MODE and COUNT_MODE. An update follows one of five named transitions. SHIFT (HIST_MODE to HIST_MODE) shifts the outcome in. ENTER_COUNT (HIST_MODE to COUNT_MODE) fires when the shifted history is uniform. COUNT_UP (COUNT_MODE to COUNT_MODE) adds one to the run length. HOLD_SAT (COUNT_MODE to COUNT_MODE) keeps a counter that is already at its maximum. EXIT_COUNT (COUNT_MODE to HIST_MODE) fires when the outcome breaks the run.

Top module: `loopcnt_pred`

## Requirements
- R1: After reset every history entry is in HIST_MODE with history value 0 and direction bit 0. Every pattern counter holds 2'b10 (weakly taken), so every lookup predicts taken (lk_taken = 1).
- R2: lk_taken is the upper bit of the pattern counter at index {state bit (1 = COUNT_MODE), direction bit, value} of the entry at lk_idx. It is combinational. A lookup and an update to the same entry in the same cycle return the value from before the update.
- R3: On an update in HIST_MODE (transition SHIFT), the entry's value shifts left by one and the outcome enters bit 0 (1 = taken). The pattern counter selected by the entry's pre-update state moves up by one on taken and down by one on not-taken, saturating at 0 and 3.
- R4: In HIST_MODE, if the shifted history is all ones or all zeros, the entry takes ENTER_COUNT. Its state becomes COUNT_MODE, its direction bit becomes the outcome, and its count is loaded with HIST_W.
- R5: In COUNT_MODE, an outcome equal to the direction bit increments the count (COUNT_UP). At 2**HIST_W-1 the count holds instead of wrapping (HOLD_SAT), and the entry stays in COUNT_MODE.
- R6: In COUNT_MODE, an outcome that differs from the direction bit takes EXIT_COUNT. The entry returns to HIST_MODE with the old direction in every bit but bit 0, the new outcome in bit 0, and direction bit 0.
- R7: A loop branch of trip count N, with HIST_W+1 < N <= 2**HIST_W (N-1 taken, then one not-taken), is predicted taken on iterations 1 to N-1 and not-taken on iteration N after one training pass from reset.
- R8: A short loop of trip count 4 with HIST_W = 4 is caught in HIST_MODE. The history 4'b0111 (one not-taken, then three taken) selects a counter that predicts not-taken.
- R9: A branch that runs not-taken and is taken once per run is counted as well. After two training passes of 9 not-taken and 1 taken, it is predicted not-taken on iterations 1 to 9 and taken on iteration 10.
- R10: Updates to one entry leave every other history entry unchanged. Entries share only the pattern table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | IDX_W | Lookup index into the history table |
| lk_taken | output | 1 | Predicted direction for lk_idx, 1 = taken |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_idx | input | IDX_W | History entry of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach is a count at its maximum, fed one more matching outcome, while the pattern counter at that maximum already leans not-taken. A wrapped count would then select an untrained counter. To build that state, one branch runs a loop whose exit falls exactly on the maximum count, for two passes, which drives the shared counter at that count to zero. A second branch then counts up to the maximum and receives one extra taken outcome, and its predictions are read with lookup-only cycles. The same-cycle lookup rule is covered by the loop scenarios: every iteration presents the lookup and the update on one entry together, and the prediction is sampled before the edge.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

    typedef enum logic {
        HIST_MODE  = 1'b0,
        COUNT_MODE = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        XF_SHIFT       = 3'd0,
        XF_ENTER_COUNT = 3'd1,
        XF_COUNT_UP    = 3'd2,
        XF_HOLD_SAT    = 3'd3,
        XF_EXIT_COUNT  = 3'd4
    } xfer_e;

endpackage

// File: rtl/lcp_hist_table.sv
module lcp_hist_table
    import lcp_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 4,
    parameter int PT_W   = HIST_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PT_W-1:0]   rd_pt_idx,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_taken,
    output logic [PT_W-1:0]   upd_pt_idx,
    output mode_e             upd_mode,
    output logic              upd_dir,
    output logic [HIST_W-1:0] upd_val,
    output xfer_e             upd_xfer
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [HIST_W-1:0] CNT_MAX  = '1;
    localparam logic [HIST_W-1:0] CNT_LOAD = HIST_W'(HIST_W);

    mode_e             mode_q [ENTRIES];
    logic              dir_q  [ENTRIES];
    logic [HIST_W-1:0] val_q  [ENTRIES];

    mode_e             nxt_mode;
    logic              nxt_dir;
    logic [HIST_W-1:0] nxt_val;
    logic [HIST_W-1:0] shifted;

    // Current state of both addressed entries.
    assign upd_mode = mode_q[upd_idx];
    assign upd_dir  = dir_q[upd_idx];
    assign upd_val  = val_q[upd_idx];
    assign shifted  = {upd_val[HIST_W-2:0], upd_taken};

    assign rd_pt_idx  = {mode_q[rd_idx] == COUNT_MODE, dir_q[rd_idx], val_q[rd_idx]};
    assign upd_pt_idx = {upd_mode == COUNT_MODE, upd_dir, upd_val};

    // Transition selection.
    always_comb begin
        upd_xfer = XF_SHIFT;
        unique case (upd_mode)
            HIST_MODE: begin
                if ((shifted == '0) || (shifted == '1))
                    upd_xfer = XF_ENTER_COUNT;
                else
                    upd_xfer = XF_SHIFT;
            end
            COUNT_MODE: begin
                if (upd_taken != upd_dir)
                    upd_xfer = XF_EXIT_COUNT;
                else if (upd_val == CNT_MAX)
                    upd_xfer = XF_HOLD_SAT;
                else
                    upd_xfer = XF_COUNT_UP;
            end
            default: upd_xfer = XF_SHIFT;
        endcase
    end

    // Entry contents produced by each transition.
    always_comb begin
        nxt_mode = upd_mode;
        nxt_dir  = upd_dir;
        nxt_val  = upd_val;
        unique case (upd_xfer)
            XF_SHIFT: begin
                nxt_mode = HIST_MODE;
                nxt_dir  = 1'b0;
                nxt_val  = shifted;
            end
            XF_ENTER_COUNT: begin
                nxt_mode = COUNT_MODE;
                nxt_dir  = upd_taken;
                nxt_val  = CNT_LOAD;
            end
            XF_COUNT_UP: begin
                nxt_mode = COUNT_MODE;
                nxt_val  = upd_val + 1'b1;
            end
            XF_HOLD_SAT: begin
                nxt_mode = COUNT_MODE;
                nxt_val  = CNT_MAX;
            end
            XF_EXIT_COUNT: begin
                nxt_mode = HIST_MODE;
                nxt_dir  = 1'b0;
                nxt_val  = {{(HIST_W-1){upd_dir}}, upd_taken};
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mode_q[i] <= HIST_MODE;
                dir_q[i]  <= 1'b0;
                val_q[i]  <= '0;
            end
        end else if (upd_valid) begin
            mode_q[upd_idx] <= nxt_mode;
            dir_q[upd_idx]  <= nxt_dir;
            val_q[upd_idx]  <= nxt_val;
        end
    end

endmodule

// File: rtl/lcp_pattern_table.sv
module lcp_pattern_table #(
    parameter int PT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PT_W-1:0] rd_idx,
    output logic            rd_taken,
    input  logic            upd_valid,
    input  logic [PT_W-1:0] upd_idx,
    input  logic            upd_taken
);

    localparam int PT_ENTRIES = 1 << PT_W;
    localparam logic [1:0] WEAK_T = 2'b10;

    logic [1:0] ctr_q [PT_ENTRIES];
    logic [1:0] cur_ctr;

    assign rd_taken = ctr_q[rd_idx][1];
    assign cur_ctr  = ctr_q[upd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_ENTRIES; i++)
                ctr_q[i] <= WEAK_T;
        end else if (upd_valid) begin
            if (upd_taken && (cur_ctr != 2'b11))
                ctr_q[upd_idx] <= cur_ctr + 2'b01;
            else if (!upd_taken && (cur_ctr != 2'b00))
                ctr_q[upd_idx] <= cur_ctr - 2'b01;
        end
    end

endmodule

// File: rtl/loopcnt_pred.sv
module loopcnt_pred
    import lcp_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_taken
);

    localparam int PT_W = HIST_W + 2;

    logic [PT_W-1:0]   rd_pt_idx;
    logic [PT_W-1:0]   upd_pt_idx;
    mode_e             upd_mode;
    logic              upd_dir;
    logic [HIST_W-1:0] upd_val;
    xfer_e             upd_xfer;

    lcp_hist_table #(
        .IDX_W  (IDX_W),
        .HIST_W (HIST_W),
        .PT_W   (PT_W)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (lk_idx),
        .rd_pt_idx  (rd_pt_idx),
        .upd_valid  (up_valid),
        .upd_idx    (up_idx),
        .upd_taken  (up_taken),
        .upd_pt_idx (upd_pt_idx),
        .upd_mode   (upd_mode),
        .upd_dir    (upd_dir),
        .upd_val    (upd_val),
        .upd_xfer   (upd_xfer)
    );

    lcp_pattern_table #(
        .PT_W (PT_W)
    ) u_pt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_pt_idx),
        .rd_taken  (lk_taken),
        .upd_valid (up_valid),
        .upd_idx   (upd_pt_idx),
        .upd_taken (up_taken)
    );

endmodule

// File: rtl/lcp_checker.sv
module lcp_checker
    import lcp_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic [IDX_W-1:0]  up_idx,
    input logic              up_taken,
    input mode_e             cur_mode,
    input logic              cur_dir,
    input logic [HIST_W-1:0] cur_val
);

    localparam logic [HIST_W-1:0] CNT_MAX  = '1;
    localparam logic [HIST_W-1:0] CNT_LOAD = HIST_W'(HIST_W);

    // R3: a non-uniform shift leaves the entry in shift state with the outcome in bit 0
    a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && cur_mode == HIST_MODE
         && {cur_val[HIST_W-2:0], up_taken} != '0
         && {cur_val[HIST_W-2:0], up_taken} != '1)
        |=> (up_idx != $past(up_idx))
            || (cur_mode == HIST_MODE
                && cur_val == {$past(cur_val[HIST_W-2:0]), $past(up_taken)}));

    // R4: uniform history moves the entry into count state with the load value
    a_r4_enter_count: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && cur_mode == HIST_MODE
         && ({cur_val[HIST_W-2:0], up_taken} == '0
             || {cur_val[HIST_W-2:0], up_taken} == '1))
        |=> (up_idx != $past(up_idx))
            || (cur_mode == COUNT_MODE && cur_val == CNT_LOAD
                && cur_dir == $past(up_taken)));

    // R5: a matching outcome below the maximum adds exactly one
    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && cur_mode == COUNT_MODE && up_taken == cur_dir
         && cur_val != CNT_MAX)
        |=> (up_idx != $past(up_idx))
            || (cur_mode == COUNT_MODE && cur_val == $past(cur_val) + 1'b1));

    // R5: a matching outcome at the maximum does not wrap
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && cur_mode == COUNT_MODE && up_taken == cur_dir
         && cur_val == CNT_MAX)
        |=> (up_idx != $past(up_idx))
            || (cur_mode == COUNT_MODE && cur_val == CNT_MAX));

    // R6: a breaking outcome returns the entry to shift state
    a_r6_exit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && cur_mode == COUNT_MODE && up_taken != cur_dir)
        |=> (up_idx != $past(up_idx))
            || (cur_mode == HIST_MODE && cur_val[0] == $past(up_taken)
                && cur_val[HIST_W-1] == $past(cur_dir)));

    // R10: without an update the addressed entry holds still
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid)
        |=> (up_idx != $past(up_idx))
            || ($stable(cur_val) && $stable(cur_mode) && $stable(cur_dir)));

endmodule

bind loopcnt_pred lcp_checker #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_idx   (up_idx),
    .up_taken (up_taken),
    .cur_mode (upd_mode),
    .cur_dir  (upd_dir),
    .cur_val  (upd_val)
);

// File: tb/loopcnt_pred_tb.sv
module loopcnt_pred_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 3;
    localparam int HIST_W     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] lk_idx = '0;
    logic             lk_taken;
    logic             up_valid = 1'b0;
    logic [IDX_W-1:0] up_idx = '0;
    logic             up_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loopcnt_pred #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_taken (lk_taken),
        .up_valid (up_valid),
        .up_idx   (up_idx),
        .up_taken (up_taken)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drives one cycle from a falling edge; the prediction is sampled before the rising edge.
    task automatic step(input logic [IDX_W-1:0] idx, input logic upd,
                        input logic tk, output logic pred);
        lk_idx   = idx;
        up_idx   = idx;
        up_valid = upd;
        up_taken = tk;
        #(CLK_PERIOD/4);
        pred = lk_taken;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        up_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_pass(input logic [IDX_W-1:0] idx, input int len,
                            input logic run_dir, input logic chk, input string tag);
        logic p;
        for (int i = 1; i <= len; i++) begin
            logic tk;
            tk = (i == len) ? ~run_dir : run_dir;
            step(idx, 1'b1, tk, p);
            if (chk) check($sformatf("%s iter %0d", tag, i), p, tk);
        end
    endtask

    task automatic t_reset_state();
        logic p;
        do_reset();
        step(3'd0, 1'b0, 1'b0, p); check("R1 idx0", p, 1'b1);
        step(3'd3, 1'b0, 1'b0, p); check("R1 idx3", p, 1'b1);
        step(3'd7, 1'b0, 1'b0, p); check("R1 idx7", p, 1'b1);
    endtask

    task automatic t_long_loop();
        do_reset();
        run_pass(3'd5, 10, 1'b1, 1'b0, "");
        // R7 R4 R5 R2: exit predicted only on iteration 10
        run_pass(3'd5, 10, 1'b1, 1'b1, "R7 long loop");
    endtask

    task automatic t_short_loop();
        do_reset();
        run_pass(3'd2, 4, 1'b1, 1'b0, "");
        // R8 R3: history 0111 predicts the exit
        run_pass(3'd2, 4, 1'b1, 1'b1, "R8 short loop");
    endtask

    task automatic t_nt_runs();
        do_reset();
        run_pass(3'd6, 10, 1'b0, 1'b0, "");
        run_pass(3'd6, 10, 1'b0, 1'b0, "");
        // R9 R6: not-taken runs counted, taken break predicted
        run_pass(3'd6, 10, 1'b0, 1'b1, "R9 nt runs");
    endtask

    task automatic t_saturate();
        logic p;
        do_reset();
        run_pass(3'd1, 16, 1'b1, 1'b0, "");
        run_pass(3'd1, 16, 1'b1, 1'b0, "");
        for (int i = 0; i < 15; i++) step(3'd3, 1'b1, 1'b1, p);
        step(3'd3, 1'b0, 1'b0, p);
        check("R5 count at max selects trained counter", p, 1'b0);
        step(3'd3, 1'b1, 1'b1, p);
        step(3'd3, 1'b0, 1'b0, p);
        check("R5 count holds at max", p, 1'b0);
        // R10: branch 1 sits at history 1110, trained taken
        step(3'd1, 1'b0, 1'b0, p);
        check("R10 other entry untouched", p, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_long_loop();
        t_short_loop();
        t_nt_runs();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule